// File: doc/BRIEF.md
# MSI-X Vector Table Controller

This block holds a small table of interrupt vectors that a host programs through memory-mapped register accesses. The host reaches it through a BAR decode and sends an offset, an access size and write data. Each vector has an address, a data word and a vector-control word, and it comes out of reset masked. Next to the table sits a pending-bit region. That region reads as zero in this block, because real pending tracking is not built.

Device logic asks for an interrupt by giving a vector index. The block turns an allowed request into a message carrying an 8-bit destination and an 8-bit vector number. The block also holds the enable bit and the function-mask bit of the capability's message control word. It reports that word with a read-only table-size field.

Top module: `msix_vtab`

## Requirements
- R1: After reset every vector's four dwords are zero, except that bit 0 of the vector-control dword is 1 (masked). The enable and function-mask bits are 0. `rd_valid` and `msg_valid` are low.
- R2: Vector `i` occupies offsets `16*i` to `16*i+15` as four dwords: byte 0 is address low, byte 4 is address high, byte 8 is the data word and byte 12 is vector control. A 4-byte access at a multiple of 4 writes or reads one dword, and a read returns it zero-extended to 64 bits. Every read request is answered with `rd_valid` high for exactly the next cycle.
- R3: An 8-byte access at a byte offset within the vector that is a multiple of 8 covers two dwords. The lower address holds bits 31:0 of the data and the higher address holds bits 63:32.
- R4: An access whose size is neither 4 nor 8 changes nothing when written and reads as all ones.
- R5: An access whose byte offset within the vector is not a multiple of its size is dropped on write and reads as all ones.
- R6: A write to a vector index at or beyond `NUM_VEC` changes no entry. A read that lies beyond the table and outside the pending region returns all ones.
- R7: The pending region starts at `NUM_VEC*16` rounded up to a multiple of 4096 and spans `((NUM_VEC-1)/64+1)*8` bytes. Aligned reads inside it return zero, and writes to it change nothing.
- R8: `cap_msgctl` carries the enable bit in bit 15 and the function-mask bit in bit 14, both loaded from `cap_wr_data` on `cap_wr_valid`. Bits 10:0 read `NUM_VEC-1` and cannot be written, and bits 13:11 read zero.
- R9: An interrupt request yields a message one cycle later only if all of these hold: enable is 1, `msi_en` is 0, function mask is 0, the index is below `NUM_VEC`, and the vector's mask bit is 0. The message is a single-cycle `msg_valid` pulse, and no message appears without a request.
- R10: `msg_dest` is bits 19:12 of the address-low dword and `msg_vector` is bits 7:0 of the data dword. Both are taken from the entry as it stood before any table write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Register access request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFS_W | Byte offset within the BAR |
| req_size | input | 4 | Access size in bytes |
| req_wdata | input | 64 | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | 64 | Read data |
| cap_wr_valid | input | 1 | Message control word write |
| cap_wr_data | input | 16 | Message control write data |
| msi_en | input | 1 | Plain MSI enabled elsewhere |
| cap_msgctl | output | 16 | Message control word |
| irq_valid | input | 1 | Interrupt request |
| irq_index | input | IRQ_W | Requested vector index |
| msg_valid | output | 1 | Message strobe |
| msg_dest | output | 8 | Message destination |
| msg_vector | output | 8 | Message vector number |

## Verification
A table write and an interrupt request can land on the same entry in the same cycle. The bench provokes this by rewriting the data word and the mask of vector 0 while that vector is requested. It expects the message to carry the old vector number and the old mask outcome, and the next request to see the new values. A read of the same entry is also issued together with a request, and both responses are checked in the following cycle.

// File: rtl/msix_vtab_pkg.sv
package msix_vtab_pkg;
   localparam int DW_ADDR_LO = 0;
   localparam int DW_ADDR_HI = 1;
   localparam int DW_DATA    = 2;
   localparam int DW_VCTL    = 3;
   localparam int ENTRY_BYTES = 16;
   localparam int PBA_ALIGN   = 4096;
   localparam int MAX_VEC     = 2048;

   typedef struct packed {
      logic       ok;      // legal size and alignment
      logic       in_tab;  // index inside table
      logic       in_pba;  // offset inside pending region
      logic       wide;    // 8-byte access
      logic [1:0] dw;      // dword slot inside the entry
   } acc_t;
endpackage

// File: rtl/msix_vtab_dec.sv
module msix_vtab_dec
   import msix_vtab_pkg::*;
#(
   parameter int NUM_VEC = 3,
   parameter int OFS_W   = 16,
   localparam int IDX_W  = OFS_W - 4
) (
   input  logic [OFS_W-1:0] off,
   input  logic [3:0]       size,
   output logic [IDX_W-1:0] idx,
   output acc_t             acc
);
   localparam int TAB_BYTES = NUM_VEC * ENTRY_BYTES;
   localparam int PBA_OFS   = ((TAB_BYTES + PBA_ALIGN - 1) / PBA_ALIGN) * PBA_ALIGN;
   localparam int PBA_BYTES = ((NUM_VEC - 1) / 64 + 1) * 8;
   localparam logic [OFS_W:0] PBA_LO = (OFS_W+1)'(PBA_OFS);
   localparam logic [OFS_W:0] PBA_HI = (OFS_W+1)'(PBA_OFS + PBA_BYTES);
   localparam logic [IDX_W:0] VEC_LIM = (IDX_W+1)'(NUM_VEC);

   generate
      if (PBA_OFS + PBA_BYTES > (1 << OFS_W)) begin : g_bad_ofs
         $error("OFS_W too narrow for table plus pending region");
      end
   endgenerate

   logic size_ok, align_ok;

   always_comb begin
      size_ok  = (size == 4'd4) || (size == 4'd8);
      align_ok = (size == 4'd8) ? (off[2:0] == 3'b000) : (off[1:0] == 2'b00);
      idx      = off[OFS_W-1:4];
      acc.ok     = size_ok && align_ok;
      acc.wide   = (size == 4'd8);
      acc.dw     = off[3:2];
      acc.in_tab = {1'b0, idx} < VEC_LIM;
      acc.in_pba = ({1'b0, off} >= PBA_LO) && ({1'b0, off} < PBA_HI);
   end
endmodule

// File: rtl/msix_vtab_store.sv
module msix_vtab_store
   import msix_vtab_pkg::*;
#(
   parameter int NUM_VEC = 3,
   parameter int IDX_W   = 12,
   parameter int IRQ_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [1:0]       wr_dw,
   input  logic             wr_wide,
   input  logic [63:0]      wr_data,
   input  logic [IDX_W-1:0] rd_idx,
   input  logic [1:0]       rd_dw,
   input  logic             rd_wide,
   output logic [63:0]      rd_word,
   input  logic [IRQ_W-1:0] sel_idx,
   output logic [7:0]       sel_dest,
   output logic [7:0]       sel_vec,
   output logic             sel_masked
);
   localparam int VI_W = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1;

   logic [31:0] tab_q [NUM_VEC][4];
   logic [VI_W-1:0] rd_sel, irq_sel;
   logic [1:0] rd_dw_hi;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int v = 0; v < NUM_VEC; v++) begin
            for (int d = 0; d < 4; d++) begin
               tab_q[v][d] <= (d == DW_VCTL) ? 32'h1 : 32'h0;
            end
         end
      end else if (wr_en) begin
         for (int v = 0; v < NUM_VEC; v++) begin
            if (wr_idx == IDX_W'(v)) begin
               tab_q[v][wr_dw] <= wr_data[31:0];
               if (wr_wide) tab_q[v][wr_dw | 2'b01] <= wr_data[63:32];
            end
         end
      end
   end

   always_comb begin
      rd_sel   = (rd_idx < IDX_W'(NUM_VEC)) ? VI_W'(rd_idx) : '0;
      irq_sel  = (sel_idx < IRQ_W'(NUM_VEC)) ? VI_W'(sel_idx) : '0;
      rd_dw_hi = rd_dw | 2'b01;
      rd_word  = rd_wide ? {tab_q[rd_sel][rd_dw_hi], tab_q[rd_sel][rd_dw]}
                         : {32'h0, tab_q[rd_sel][rd_dw]};
      sel_dest   = tab_q[irq_sel][DW_ADDR_LO][19:12];
      sel_vec    = tab_q[irq_sel][DW_DATA][7:0];
      sel_masked = tab_q[irq_sel][DW_VCTL][0];
   end

   AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> (wr_idx < IDX_W'(NUM_VEC))); // R6
   AST_WIDE_EVEN_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_wide) |-> !wr_dw[0]); // R3
endmodule

// File: rtl/msix_vtab_msg.sv
module msix_vtab_msg #(
   parameter int NUM_VEC = 3,
   parameter int IRQ_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_valid,
   input  logic [IRQ_W-1:0] irq_index,
   input  logic             en,
   input  logic             fmask,
   input  logic             msi_en,
   input  logic             sel_masked,
   input  logic [7:0]       sel_dest,
   input  logic [7:0]       sel_vec,
   output logic             msg_valid,
   output logic [7:0]       msg_dest,
   output logic [7:0]       msg_vector
);
   logic fire;

   always_comb begin
      fire = irq_valid && en && !msi_en && !fmask &&
             (irq_index < IRQ_W'(NUM_VEC)) && !sel_masked;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_valid  <= 1'b0;
         msg_dest   <= 8'h0;
         msg_vector <= 8'h0;
      end else begin
         msg_valid <= fire;
         if (fire) begin
            msg_dest   <= sel_dest;
            msg_vector <= sel_vec;
         end
      end
   end

   AST_MSG_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> $past(irq_valid)); // R9
   AST_MSG_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> $past(en && !fmask && !msi_en)); // R9
endmodule

// File: rtl/msix_vtab.sv
module msix_vtab
   import msix_vtab_pkg::*;
#(
   parameter int NUM_VEC = 3,
   parameter int OFS_W   = 16,
   parameter int IRQ_W   = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [OFS_W-1:0] req_offset,
   input  logic [3:0]       req_size,
   input  logic [63:0]      req_wdata,
   output logic             rd_valid,
   output logic [63:0]      rd_data,
   input  logic             cap_wr_valid,
   input  logic [15:0]      cap_wr_data,
   input  logic             msi_en,
   output logic [15:0]      cap_msgctl,
   input  logic             irq_valid,
   input  logic [IRQ_W-1:0] irq_index,
   output logic             msg_valid,
   output logic [7:0]       msg_dest,
   output logic [7:0]       msg_vector
);
   localparam int IDX_W = OFS_W - 4;
   localparam logic [10:0] TSZ_FIELD = 11'(NUM_VEC - 1);

   generate
      if (NUM_VEC < 1 || NUM_VEC > MAX_VEC) begin : g_bad_count
         $error("NUM_VEC out of range");
      end
      if ((1 << IRQ_W) < NUM_VEC) begin : g_bad_irq
         $error("IRQ_W too narrow for NUM_VEC");
      end
   endgenerate

   acc_t             acc;
   logic [IDX_W-1:0] idx;
   logic [63:0]      tab_word;
   logic [7:0]       sel_dest, sel_vec;
   logic             sel_masked;
   logic             wr_en;
   logic             en_q, fmask_q;

   msix_vtab_dec #(.NUM_VEC(NUM_VEC), .OFS_W(OFS_W)) u_dec (
      .off(req_offset), .size(req_size), .idx(idx), .acc(acc)
   );

   assign wr_en = req_valid && req_write && acc.ok && acc.in_tab;

   msix_vtab_store #(.NUM_VEC(NUM_VEC), .IDX_W(IDX_W), .IRQ_W(IRQ_W)) u_store (
      .clk(clk), .rst_n(rst_n),
      .wr_en(wr_en), .wr_idx(idx), .wr_dw(acc.dw), .wr_wide(acc.wide),
      .wr_data(req_wdata),
      .rd_idx(idx), .rd_dw(acc.dw), .rd_wide(acc.wide), .rd_word(tab_word),
      .sel_idx(irq_index), .sel_dest(sel_dest), .sel_vec(sel_vec),
      .sel_masked(sel_masked)
   );

   msix_vtab_msg #(.NUM_VEC(NUM_VEC), .IRQ_W(IRQ_W)) u_msg (
      .clk(clk), .rst_n(rst_n),
      .irq_valid(irq_valid), .irq_index(irq_index),
      .en(en_q), .fmask(fmask_q), .msi_en(msi_en),
      .sel_masked(sel_masked), .sel_dest(sel_dest), .sel_vec(sel_vec),
      .msg_valid(msg_valid), .msg_dest(msg_dest), .msg_vector(msg_vector)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q    <= 1'b0;
         fmask_q <= 1'b0;
      end else if (cap_wr_valid) begin
         en_q    <= cap_wr_data[15];
         fmask_q <= cap_wr_data[14];
      end
   end

   assign cap_msgctl = {en_q, fmask_q, 3'b000, TSZ_FIELD};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= req_valid && !req_write;
         if (req_valid && !req_write) begin
            if (!acc.ok)         rd_data <= '1;
            else if (acc.in_tab) rd_data <= tab_word;
            else if (acc.in_pba) rd_data <= '0;
            else                 rd_data <= '1;
         end
      end
   end

   AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> $past(req_valid && !req_write)); // R2
   AST_BAD_SIZE_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_write && req_size != 4'd4 && req_size != 4'd8)
      |=> (rd_data == '1)); // R4
endmodule

// File: tb/msix_vtab_bench.sv
module msix_vtab_bench;
   localparam int CLK_PERIOD = 10;
   localparam int N = 3;
   localparam int OW = 16;
   localparam int IW = 12;
   localparam int PBA_OFS = 4096;
   localparam int PBA_BYTES = 8;

   logic clk = 0, rst_n = 0;
   logic req_valid = 0, req_write = 0;
   logic [OW-1:0] req_offset = '0;
   logic [3:0] req_size = '0;
   logic [63:0] req_wdata = '0;
   logic rd_valid;
   logic [63:0] rd_data;
   logic cap_wr_valid = 0;
   logic [15:0] cap_wr_data = '0;
   logic msi_en = 0;
   logic [15:0] cap_msgctl;
   logic irq_valid = 0;
   logic [IW-1:0] irq_index = '0;
   logic msg_valid;
   logic [7:0] msg_dest, msg_vector;

   always #(CLK_PERIOD/2) clk = ~clk;

   msix_vtab #(.NUM_VEC(N), .OFS_W(OW), .IRQ_W(IW)) u_msix_vtab (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_offset(req_offset), .req_size(req_size), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data), .cap_wr_valid(cap_wr_valid),
      .cap_wr_data(cap_wr_data), .msi_en(msi_en), .cap_msgctl(cap_msgctl),
      .irq_valid(irq_valid), .irq_index(irq_index), .msg_valid(msg_valid),
      .msg_dest(msg_dest), .msg_vector(msg_vector)
   );

   int checks = 0, fails = 0;
   bit done = 0;
   bit [31:0] m_tab [N][4];
   bit m_en, m_fm;

   task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
      end
   endtask

   function automatic logic [63:0] model_read(int off, int sz);
      int b, idx;
      if (sz != 4 && sz != 8) return '1;
      b = off % 16;
      if (b % sz != 0) return '1;
      idx = off / 16;
      if (idx < N) begin
         if (sz == 4) return {32'h0, m_tab[idx][b/4]};
         return {m_tab[idx][b/4+1], m_tab[idx][b/4]};
      end
      if (off >= PBA_OFS && off < PBA_OFS + PBA_BYTES) return '0;
      return '1;
   endfunction

   task automatic model_write(int off, int sz, logic [63:0] wd);
      int b, idx;
      if (sz != 4 && sz != 8) return;
      b = off % 16;
      if (b % sz != 0) return;
      idx = off / 16;
      if (idx >= N) return;
      m_tab[idx][b/4] = wd[31:0];
      if (sz == 8) m_tab[idx][b/4+1] = wd[63:32];
   endtask

   task automatic model_reset();
      for (int v = 0; v < N; v++)
         for (int d = 0; d < 4; d++) m_tab[v][d] = (d == 3) ? 32'h1 : 32'h0;
      m_en = 0; m_fm = 0;
   endtask

   // one clock: drive at negedge, predict, check at next negedge
   task automatic apply(string tag, bit rv, bit rw, int off, int sz, logic [63:0] wd,
                        bit cw, logic [15:0] cd, bit iv, int ii, bit msi);
      bit e_rv, e_mv;
      logic [63:0] e_rd;
      logic [7:0] e_dest, e_vec;
      req_valid = rv; req_write = rw; req_offset = OW'(off); req_size = 4'(sz);
      req_wdata = wd; cap_wr_valid = cw; cap_wr_data = cd;
      irq_valid = iv; irq_index = IW'(ii); msi_en = msi;
      e_rv = rv && !rw;
      e_rd = model_read(off, sz);
      e_mv = iv && m_en && !msi && !m_fm && ii < N && !m_tab[ii < N ? ii : 0][3][0];
      e_dest = m_tab[ii < N ? ii : 0][0][19:12];
      e_vec  = m_tab[ii < N ? ii : 0][2][7:0];
      if (cw) begin m_en = cd[15]; m_fm = cd[14]; end
      if (rv && rw) model_write(off, sz, wd);
      @(negedge clk);
      chk(tag, "rd_valid", {63'h0, rd_valid}, {63'h0, e_rv});
      if (e_rv) chk(tag, "rd_data", rd_data, e_rd);
      chk(tag, "msg_valid", {63'h0, msg_valid}, {63'h0, e_mv});
      if (e_mv) begin
         chk(tag, "msg_dest", {56'h0, msg_dest}, {56'h0, e_dest});
         chk(tag, "msg_vector", {56'h0, msg_vector}, {56'h0, e_vec});
      end
      chk(tag, "cap_msgctl", {48'h0, cap_msgctl},
          {48'h0, m_en, m_fm, 3'b000, 11'(N-1)});
   endtask

   task automatic wr(string tag, int off, int sz, logic [63:0] wd);
      apply(tag, 1, 1, off, sz, wd, 0, 0, 0, 0, 0);
   endtask
   task automatic rd(string tag, int off, int sz);
      apply(tag, 1, 0, off, sz, 0, 0, 0, 0, 0, 0);
   endtask
   task automatic irq(string tag, int ii, bit msi);
      apply(tag, 0, 0, 0, 4, 0, 0, 0, 1, ii, msi);
   endtask
   task automatic capw(string tag, logic [15:0] cd);
      apply(tag, 0, 0, 0, 4, 0, 1, cd, 0, 0, 0);
   endtask

   initial begin
      model_reset();
      repeat (3) @(negedge clk);
      rst_n = 1;
      // R1: reset state
      apply("R1", 0, 0, 0, 4, 0, 0, 0, 0, 0, 0);
      for (int v = 0; v < N; v++) begin
         rd("R1", v*16 + 12, 4);
         rd("R1", v*16, 8);
      end
      // R2: dword writes and reads
      wr("R2", 16, 4, 64'h0_000AB000);
      wr("R2", 24, 4, 64'h0_00000055);
      rd("R2", 16, 4); rd("R2", 24, 4); rd("R2", 20, 4);
      // R3: 8-byte halves
      wr("R3", 0, 8, 64'h12345678_00034000);
      wr("R3", 8, 8, 64'h00000000_00000021);
      rd("R3", 0, 8); rd("R3", 4, 4); rd("R3", 8, 8); rd("R3", 12, 4);
      // R4: bad sizes
      wr("R4", 16, 2, 64'hFFFF);
      wr("R4", 16, 1, 64'hFF);
      rd("R4", 16, 4); rd("R4", 16, 1); rd("R4", 16, 2); rd("R4", 0, 16);
      // R5: misaligned
      wr("R5", 4, 8, 64'hDEADBEEF_CAFEF00D);
      wr("R5", 18, 4, 64'h77);
      rd("R5", 0, 8); rd("R5", 16, 8); rd("R5", 4, 8); rd("R5", 2, 4);
      // R6: beyond table
      wr("R6", 48, 4, 64'h1234);
      wr("R6", 48, 8, 64'h1234);
      rd("R6", 48, 4); rd("R6", 100, 8); rd("R6", 40, 8); rd("R6", 32, 8);
      // R7: pending region
      wr("R7", PBA_OFS, 8, '1);
      rd("R7", PBA_OFS, 4); rd("R7", PBA_OFS, 8); rd("R7", PBA_OFS + 4, 4);
      rd("R7", PBA_OFS + 8, 4); rd("R7", PBA_OFS - 4, 4); rd("R7", PBA_OFS + 2, 4);
      // R8: capability word
      capw("R8", 16'h87FF);
      capw("R8", 16'h47FF);
      capw("R8", 16'h8000);
      // R9: gating
      irq("R9", 0, 0);
      irq("R9", 1, 0);
      wr("R9", 28, 4, 0);
      irq("R9", 1, 0);
      irq("R9", 3, 0);
      irq("R9", 0, 1);
      capw("R9", 16'hC000);
      irq("R9", 0, 0);
      capw("R9", 16'h0000);
      irq("R9", 0, 0);
      capw("R9", 16'h8000);
      irq("R9", 2, 0);
      apply("R9", 0, 0, 0, 4, 0, 0, 0, 0, 0, 0);
      // R10: fields and same-cycle write versus request
      irq("R10", 0, 0); irq("R10", 1, 0);
      apply("R10", 1, 1, 8, 4, 64'h99, 0, 0, 1, 0, 0);
      irq("R10", 0, 0);
      apply("R10", 1, 1, 12, 4, 64'h1, 0, 0, 1, 0, 0);
      irq("R10", 0, 0);
      apply("R10", 1, 0, 16, 8, 0, 0, 0, 1, 1, 0);
      apply("R10", 1, 1, 16, 4, 64'h00FF_F000, 0, 0, 1, 1, 0);
      irq("R10", 1, 0);
      apply("R10", 0, 0, 0, 4, 0, 0, 0, 0, 0, 0);
      if (!done) begin
         done = 1;
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         fails++;
         $display("FAIL watchdog expired");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end
endmodule